// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the stack work of taking an interrupt or exception and of returning from one. When a request is accepted it latches the caller's architectural state (flags, code selector, instruction pointer, stack selector, stack pointer and current privilege level). It then asks an external gate table for the handler entry of the chosen vector and writes the handler frame onto the stack one word per cycle. When the handler runs at a more privileged level, the frame goes onto that level's own stack, which is taken from a per-level table input. At the end it presents the updated register values for one cycle, together with a done strobe.

The return sequence reads the frame back from the current stack. A frame whose saved selector names a less privileged level also carries the interrupted stack, and that stack is restored as well. Requests come from four sources: exceptions with a vector and error code, the non-maskable interrupt, the overflow trap, and maskable external interrupts. A fifth input starts a return. All of them are single-cycle strobes and are sampled only while the sequencer is idle. The memory port makes at most one access per cycle, and read data is expected in the same cycle as the read strobe.

Top module: `ies_seq`

## Requirements
- R1: After reset the sequencer is idle: `ready` is 1, and `done`, `mem_we` and `mem_re` are 0.
- R2: When the gate level equals the current level, the sequencer writes flags, code selector, instruction pointer and, if one applies, the error code at the addresses sp-4, sp-8, sp-12 and sp-16, in that order. The final stack pointer is the last address written. Selectors are zero-extended to the word width.
- R3: When the gate level is numerically lower than the current level, the frame is written below that level's entry in the stack table. The words are, in order: the old stack selector, the old stack pointer, flags, code selector, instruction pointer and the optional error code. The new stack selector is the table entry for that level.
- R4: An error code word is written only for exception vectors 8, 10 to 14 and 17. No other vector and no other request source writes one.
- R5: After entry, the instruction pointer equals the gate offset and the level equals the gate level. The code selector equals the gate selector with its two low bits replaced by the gate level.
- R6: An interrupt-type gate (`gate_trap` = 0) clears flag bit 9, the interrupt enable bit. A trap-type gate leaves all flags unchanged.
- R7: The overflow-trap request dispatches vector 4 only when flag bit 11 is set. Otherwise it has no effect: there is no sequence, no memory access and no done strobe.
- R8: A maskable external request is accepted only while flag bit 9 is set. The non-maskable request always dispatches vector 2.
- R9: A gate level numerically greater than the current level raises `fault` with `done`. Nothing is written to memory, and every output register keeps the value that was latched on acceptance.
- R10: A return whose popped code selector has low bits equal to the current level reads the instruction pointer, code selector and flags at sp, sp+4 and sp+8, restores them, and sets the stack pointer to sp+12.
- R11: A return whose popped selector level is numerically greater than the current level also reads the stack pointer at sp+12 and the stack selector at sp+16, restores both, and takes the popped selector level as the new level.
- R12: When several requests arrive in the same idle cycle, exactly one is taken, in the priority order exception, non-maskable, overflow, external, return. The others are dropped, and so are requests that arrive while the sequencer is busy. The memory write and read strobes are never high together.
- R13: A return whose popped selector level is numerically lower than the current level raises `fault`, and the output registers keep their latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception request strobe |
| exc_vec | input | 8 | Exception vector |
| exc_err | input | DW | Error code for the exception |
| nmi_req | input | 1 | Non-maskable interrupt strobe (vector 2) |
| ovf_req | input | 1 | Overflow-trap strobe (vector 4 if flag bit 11 is set) |
| ext_req | input | 1 | Maskable external interrupt strobe |
| ext_vec | input | 8 | External interrupt vector (32 to 255) |
| iret_req | input | 1 | Interrupt return strobe |
| cur_flags | input | DW | Current flags |
| cur_cs | input | SELW | Current code selector |
| cur_ip | input | DW | Current instruction pointer |
| cur_ss | input | SELW | Current stack selector |
| cur_sp | input | DW | Current stack pointer |
| cur_lvl | input | LVLW | Current privilege level |
| lvl_ss_tab | input | NLVL*SELW | Stack selector of each level, level 0 in the low slice |
| lvl_sp_tab | input | NLVL*DW | Initial stack pointer of each level, level 0 in the low slice |
| gate_vec | output | 8 | Vector being looked up |
| gate_sel | input | SELW | Handler code selector for `gate_vec` |
| gate_off | input | DW | Handler offset for `gate_vec` |
| gate_lvl | input | LVLW | Handler privilege level for `gate_vec` |
| gate_trap | input | 1 | 1 = trap-type gate, 0 = interrupt-type gate |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | DW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the cycle of `mem_re` |
| ready | output | 1 | Idle; requests are sampled |
| done | output | 1 | One-cycle strobe; the new_* outputs are valid |
| fault | output | 1 | Protection fault, valid with `done` |
| new_flags | output | DW | Resulting flags |
| new_cs | output | SELW | Resulting code selector |
| new_ip | output | DW | Resulting instruction pointer |
| new_ss | output | SELW | Resulting stack selector |
| new_sp | output | DW | Resulting stack pointer |
| new_lvl | output | LVLW | Resulting privilege level |

## Verification
Two things can land in the same cycle: several request strobes can arrive together in an idle cycle, and a new request can arrive while an earlier sequence is still writing its frame. The bench raises the non-maskable and external strobes together, and separately an exception together with the non-maskable strobe. It judges which source won from the handler offset that comes back, and then watches for twenty cycles to confirm that no second sequence follows. It also raises an external strobe while a non-maskable sequence is still pushing, and expects exactly one done strobe.

// File: rtl/ies_pkg.sv
// Shared definitions for the interrupt entry/return sequencer.
// Assumes 8-bit vectors and fixed flag bit positions for the interrupt
// enable and overflow flags.
package ies_pkg;
    localparam int VECW   = 8;
    localparam int IF_BIT = 9;
    localparam int OF_BIT = 11;
    localparam logic [VECW-1:0] VEC_NMI = 8'd2;
    localparam logic [VECW-1:0] VEC_OVF = 8'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_PUSH,
        ST_POP,
        ST_DONE
    } ies_state_e;

    // True for the exception vectors whose frame carries an error code.
    function automatic logic vec_has_err(input logic [VECW-1:0] v);
        return (v == 8'd8) || ((v >= 8'd10) && (v <= 8'd14)) || (v == 8'd17);
    endfunction
endpackage

// File: rtl/ies_arbiter.sv
// Request arbiter: picks at most one request source per idle cycle.
// Priority: exception, non-maskable, overflow trap, external, return.
// Assumes all requests are one-cycle strobes; losers are not remembered.
module ies_arbiter
    import ies_pkg::*;
(
    input  logic            en,
    input  logic            exc_req,
    input  logic [VECW-1:0] exc_vec,
    input  logic            nmi_req,
    input  logic            ovf_req,
    input  logic            ext_req,
    input  logic [VECW-1:0] ext_vec,
    input  logic            iret_req,
    input  logic            if_flag,
    input  logic            of_flag,
    output logic            take,
    output logic            is_ret,
    output logic [VECW-1:0] vec,
    output logic            push_err
);
    // Fixed-priority selection, qualified by the flag conditions.
    always_comb begin
        take     = 1'b0;
        is_ret   = 1'b0;
        vec      = '0;
        push_err = 1'b0;
        if (en) begin
            if (exc_req) begin
                take     = 1'b1;
                vec      = exc_vec;
                push_err = vec_has_err(exc_vec);
            end else if (nmi_req) begin
                take = 1'b1;
                vec  = VEC_NMI;
            end else if (ovf_req && of_flag) begin
                take = 1'b1;
                vec  = VEC_OVF;
            end else if (ext_req && if_flag) begin
                take = 1'b1;
                vec  = ext_vec;
            end else if (iret_req) begin
                take   = 1'b1;
                is_ret = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ies_push_mux.sv
// Frame word selector: returns the word for push slot k of the handler
// frame. A level switch prepends the old stack selector and pointer.
// Assumes selectors are zero-extended to the word width.
module ies_push_mux #(
    parameter int DW   = 32,
    parameter int SELW = 16
) (
    input  logic          xlvl,
    input  logic [2:0]    k,
    input  logic [SELW-1:0] ss,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] flags,
    input  logic [SELW-1:0] cs,
    input  logic [DW-1:0] ip,
    input  logic [DW-1:0] err,
    output logic [DW-1:0] word
);
    localparam int PADW = DW - SELW;

    logic [2:0] slot;

    // Without a switch the first two slots of the long frame are skipped.
    assign slot = xlvl ? k : (k + 3'd2);

    // Map slot to frame word.
    always_comb begin
        case (slot)
            3'd0:    word = {{PADW{1'b0}}, ss};
            3'd1:    word = sp;
            3'd2:    word = flags;
            3'd3:    word = {{PADW{1'b0}}, cs};
            3'd4:    word = ip;
            default: word = err;
        endcase
    end
endmodule

// File: rtl/ies_seq.sv
// Interrupt entry and return sequencer.
// Entry: latch state, look up the gate, check privilege, optionally move
// to the target level's stack, push the frame one word per cycle, then
// present handler state. Return: pop ip, cs, flags (and sp, ss when the
// saved level is less privileged), then present restored state.
// Assumes same-cycle read data and a gate table that answers gate_vec
// combinationally. Levels: lower number = more privileged.
module ies_seq
    import ies_pkg::*;
#(
    parameter int DW   = 32,
    parameter int SELW = 16,
    parameter int LVLW = 2,
    localparam int NLVL = 1 << LVLW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_req,
    input  logic [VECW-1:0]      exc_vec,
    input  logic [DW-1:0]        exc_err,
    input  logic                 nmi_req,
    input  logic                 ovf_req,
    input  logic                 ext_req,
    input  logic [VECW-1:0]      ext_vec,
    input  logic                 iret_req,
    input  logic [DW-1:0]        cur_flags,
    input  logic [SELW-1:0]      cur_cs,
    input  logic [DW-1:0]        cur_ip,
    input  logic [SELW-1:0]      cur_ss,
    input  logic [DW-1:0]        cur_sp,
    input  logic [LVLW-1:0]      cur_lvl,
    input  logic [NLVL*SELW-1:0] lvl_ss_tab,
    input  logic [NLVL*DW-1:0]   lvl_sp_tab,
    output logic [VECW-1:0]      gate_vec,
    input  logic [SELW-1:0]      gate_sel,
    input  logic [DW-1:0]        gate_off,
    input  logic [LVLW-1:0]      gate_lvl,
    input  logic                 gate_trap,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 ready,
    output logic                 done,
    output logic                 fault,
    output logic [DW-1:0]        new_flags,
    output logic [SELW-1:0]      new_cs,
    output logic [DW-1:0]        new_ip,
    output logic [SELW-1:0]      new_ss,
    output logic [DW-1:0]        new_sp,
    output logic [LVLW-1:0]      new_lvl
);
    localparam int            WB       = DW / 8;
    localparam logic [DW-1:0] STEP     = DW'(WB);
    localparam logic [DW-1:0] IF_MASK  = DW'(1) << IF_BIT;
    localparam logic [SELW-1:0] LVL_MASK = SELW'((1 << LVLW) - 1);

    ies_state_e      st;
    logic [DW-1:0]   snap_flags, snap_ip, snap_sp, err_q;
    logic [SELW-1:0] snap_cs, snap_ss;
    logic [LVLW-1:0] snap_lvl, rpl_q;
    logic [VECW-1:0] vec_q;
    logic            errpush_q, xlvl_q, fault_q;
    logic [2:0]      k, nwords;
    logic [DW-1:0]   wsp;
    logic [DW-1:0]   res_flags, res_ip, res_sp;
    logic [SELW-1:0] res_cs, res_ss;
    logic [LVLW-1:0] res_lvl;

    logic            arb_take, arb_ret, arb_err;
    logic [VECW-1:0] arb_vec;
    logic            gate_up, gate_sw;
    logic [DW-1:0]   tab_sp, push_addr, push_word;
    logic [SELW-1:0] tab_ss;
    logic [2:0]      gate_n;

    ies_arbiter u_arb (
        .en       (st == ST_IDLE),
        .exc_req  (exc_req),
        .exc_vec  (exc_vec),
        .nmi_req  (nmi_req),
        .ovf_req  (ovf_req),
        .ext_req  (ext_req),
        .ext_vec  (ext_vec),
        .iret_req (iret_req),
        .if_flag  (cur_flags[IF_BIT]),
        .of_flag  (cur_flags[OF_BIT]),
        .take     (arb_take),
        .is_ret   (arb_ret),
        .vec      (arb_vec),
        .push_err (arb_err)
    );

    ies_push_mux #(.DW(DW), .SELW(SELW)) u_mux (
        .xlvl  (xlvl_q),
        .k     (k),
        .ss    (snap_ss),
        .sp    (snap_sp),
        .flags (snap_flags),
        .cs    (snap_cs),
        .ip    (snap_ip),
        .err   (err_q),
        .word  (push_word)
    );

    // Gate decode: privilege comparison, target stack and frame length.
    always_comb begin
        gate_up = gate_lvl > snap_lvl;
        gate_sw = gate_lvl < snap_lvl;
        tab_ss  = lvl_ss_tab[gate_lvl*SELW +: SELW];
        tab_sp  = lvl_sp_tab[gate_lvl*DW +: DW];
        gate_n  = (gate_sw ? 3'd5 : 3'd3) + (errpush_q ? 3'd1 : 3'd0);
    end

    // Memory port: pre-decrement on push, post-increment on pop.
    assign push_addr = wsp - STEP;
    assign mem_we    = (st == ST_PUSH);
    assign mem_re    = (st == ST_POP);
    assign mem_addr  = (st == ST_PUSH) ? push_addr : wsp;
    assign mem_wdata = push_word;

    // Status and results; a fault returns the latched state unchanged.
    assign gate_vec  = vec_q;
    assign ready     = (st == ST_IDLE);
    assign done      = (st == ST_DONE);
    assign fault     = done && fault_q;
    assign new_flags = fault_q ? snap_flags : res_flags;
    assign new_cs    = fault_q ? snap_cs    : res_cs;
    assign new_ip    = fault_q ? snap_ip    : res_ip;
    assign new_ss    = fault_q ? snap_ss    : res_ss;
    assign new_sp    = fault_q ? snap_sp    : res_sp;
    assign new_lvl   = fault_q ? snap_lvl   : res_lvl;

    // Sequencer state machine and working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            snap_flags <= '0;
            snap_ip    <= '0;
            snap_sp    <= '0;
            snap_cs    <= '0;
            snap_ss    <= '0;
            snap_lvl   <= '0;
            err_q      <= '0;
            vec_q      <= '0;
            errpush_q  <= 1'b0;
            xlvl_q     <= 1'b0;
            fault_q    <= 1'b0;
            rpl_q      <= '0;
            k          <= '0;
            nwords     <= '0;
            wsp        <= '0;
            res_flags  <= '0;
            res_ip     <= '0;
            res_sp     <= '0;
            res_cs     <= '0;
            res_ss     <= '0;
            res_lvl    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (arb_take) begin
                        snap_flags <= cur_flags;
                        snap_ip    <= cur_ip;
                        snap_sp    <= cur_sp;
                        snap_cs    <= cur_cs;
                        snap_ss    <= cur_ss;
                        snap_lvl   <= cur_lvl;
                        err_q      <= exc_err;
                        vec_q      <= arb_vec;
                        errpush_q  <= arb_err;
                        fault_q    <= 1'b0;
                        k          <= '0;
                        wsp        <= cur_sp;
                        st         <= arb_ret ? ST_POP : ST_GATE;
                    end
                end
                ST_GATE: begin
                    k <= '0;
                    if (gate_up) begin
                        fault_q <= 1'b1;
                        st      <= ST_DONE;
                    end else begin
                        xlvl_q    <= gate_sw;
                        nwords    <= gate_n;
                        wsp       <= gate_sw ? tab_sp : snap_sp;
                        res_ss    <= gate_sw ? tab_ss : snap_ss;
                        res_cs    <= (gate_sel & ~LVL_MASK) | SELW'(gate_lvl);
                        res_ip    <= gate_off;
                        res_lvl   <= gate_lvl;
                        res_flags <= gate_trap ? snap_flags : (snap_flags & ~IF_MASK);
                        st        <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    wsp    <= push_addr;
                    res_sp <= push_addr;
                    k      <= k + 3'd1;
                    if (k == (nwords - 3'd1)) begin
                        st <= ST_DONE;
                    end
                end
                ST_POP: begin
                    wsp <= wsp + STEP;
                    k   <= k + 3'd1;
                    case (k)
                        3'd0: res_ip <= mem_rdata;
                        3'd1: begin
                            res_cs <= mem_rdata[SELW-1:0];
                            rpl_q  <= mem_rdata[LVLW-1:0];
                        end
                        3'd2: begin
                            res_flags <= mem_rdata;
                            if (rpl_q < snap_lvl) begin
                                fault_q <= 1'b1;
                                st      <= ST_DONE;
                            end else if (rpl_q == snap_lvl) begin
                                res_sp  <= wsp + STEP;
                                res_ss  <= snap_ss;
                                res_lvl <= snap_lvl;
                                st      <= ST_DONE;
                            end
                        end
                        3'd3: res_sp <= mem_rdata;
                        default: begin
                            res_ss  <= mem_rdata[SELW-1:0];
                            res_lvl <= rpl_q;
                            st      <= ST_DONE;
                        end
                    endcase
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Guard: one memory access per cycle at most.
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R12
    // Guard: consecutive pushes step down one word.
    AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - STEP)); // R2
    // Guard: consecutive pops step up one word.
    AST_POP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + STEP)); // R10
    // Guard: a privilege violation at gate time never writes memory.
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_GATE) && (gate_lvl > snap_lvl)) |=> !mem_we); // R9
    // Guard: an idle sequencer makes no memory access.
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mem_we && !mem_re)); // R1
    // Guard: done is a single-cycle strobe.
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
endmodule

// File: tb/ies_seq_tb.sv
module ies_seq_tb;
    localparam int DW = 32, SELW = 16, LVLW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic exc_req, nmi_req, ovf_req, ext_req, iret_req;
    logic [7:0] exc_vec, ext_vec, gate_vec;
    logic [31:0] exc_err, cur_flags, cur_ip, cur_sp;
    logic [15:0] cur_cs, cur_ss;
    logic [1:0]  cur_lvl;
    logic [63:0]  lvl_ss_tab;
    logic [127:0] lvl_sp_tab;
    logic [15:0] gate_sel;
    logic [31:0] gate_off;
    logic [1:0]  gate_lvl;
    logic        gate_trap;
    logic        mem_we, mem_re, ready, done, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] new_flags, new_ip, new_sp;
    logic [15:0] new_cs, new_ss;
    logic [1:0]  new_lvl;

    logic [31:0] mem [0:127];
    int n_chk = 0, n_fail = 0, cyc = 0;

    // Bench model of the gate table and level stacks.
    function automatic logic [1:0] g_lvl(input logic [7:0] v); return v[2:1]; endfunction
    function automatic logic [15:0] g_sel(input logic [7:0] v); return 16'h4000 + {4'h0, v, 4'h0}; endfunction
    function automatic logic [31:0] g_off(input logic [7:0] v); return 32'h0001_0000 + {16'h0, v, 8'h00}; endfunction
    function automatic logic [31:0] t_sp(input logic [1:0] l); return 32'h100 + 32'(l) * 32'd64; endfunction
    function automatic logic [15:0] t_ss(input logic [1:0] l); return 16'h0030 + 16'(l) * 16'd17; endfunction
    function automatic bit b_err(input int v); return v == 8 || (v >= 10 && v <= 14) || v == 17; endfunction

    assign gate_sel  = g_sel(gate_vec);
    assign gate_off  = g_off(gate_vec);
    assign gate_lvl  = g_lvl(gate_vec);
    assign gate_trap = gate_vec[0];
    assign mem_rdata = mem[mem_addr[8:2]];

    always @(posedge clk) if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;

    ies_seq u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_reqs();
        exc_req = 0; nmi_req = 0; ovf_req = 0; ext_req = 0; iret_req = 0;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 128; i++) mem[i] = 32'hA5A5_0000 | 32'(i);
    endtask

    function automatic bit mem_clean();
        for (int i = 0; i < 128; i++) if (mem[i] != (32'hA5A5_0000 | 32'(i))) return 0;
        return 1;
    endfunction

    task automatic wait_done(input int lim, output bit got);
        got = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
    endtask

    task automatic set_cur(input logic [1:0] l, input logic [31:0] f);
        cur_lvl = l; cur_cs = 16'h0800 | 16'(l); cur_ss = 16'h0020 | 16'(l);
        cur_sp = 32'h0F0; cur_ip = 32'h5000; cur_flags = f;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit got;
        logic [31:0] exp_w [0:5];
        logic [31:0] base, a, fl;
        int n;
        logic [1:0] gl;
        bit xl, tr;

        clear_reqs();
        exc_vec = 0; ext_vec = 0; exc_err = 0;
        set_cur(0, 32'h0A46);
        for (int l = 0; l < 4; l++) begin
            lvl_ss_tab[l*16 +: 16] = t_ss(2'(l));
            lvl_sp_tab[l*32 +: 32] = t_sp(2'(l));
        end
        fill_mem();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ready && !done && !mem_we && !mem_re, "R1 reset idle", {ready, done, mem_we, mem_re}, 4'b1000);

        // Sweep: exceptions 0..31 from every current level.
        for (int cl = 0; cl < 4; cl++) begin
            for (int v = 0; v < 32; v++) begin
                fill_mem();
                set_cur(2'(cl), 32'h0A46);
                cur_ip = 32'h5000 + 32'(v);
                @(negedge clk);
                exc_req = 1; exc_vec = 8'(v); exc_err = 32'hE000_0000 + 32'(v);
                @(negedge clk);
                clear_reqs();
                wait_done(40, got);
                chk(got, "R2 sequence completes", 64'(got), 1);
                gl = g_lvl(8'(v)); tr = v[0];
                if (int'(gl) > cl) begin
                    chk(fault, "R9 fault raised", 64'(fault), 1);
                    chk(new_ip == cur_ip && new_sp == cur_sp && new_lvl == cur_lvl && new_cs == cur_cs
                        && new_flags == cur_flags && new_ss == cur_ss, "R9 regs kept", {new_ip, new_sp}, {cur_ip, cur_sp});
                    chk(mem_clean(), "R9 no write", 0, 0);
                end else begin
                    xl = int'(gl) < cl;
                    n = 0;
                    if (xl) begin
                        exp_w[0] = {16'h0, cur_ss}; exp_w[1] = cur_sp; n = 2;
                    end
                    exp_w[n] = cur_flags; exp_w[n+1] = {16'h0, cur_cs}; exp_w[n+2] = cur_ip; n += 3;
                    if (b_err(v)) begin exp_w[n] = exc_err; n++; end
                    base = xl ? t_sp(gl) : 32'h0F0;
                    for (int i = 0; i < n; i++) begin
                        a = base - 32'(4 * (i + 1));
                        chk(mem[a[8:2]] == exp_w[i], xl ? "R3 frame word" : "R2 frame word", mem[a[8:2]], exp_w[i]);
                    end
                    a = base - 32'(4 * (n + 1));
                    chk(mem[a[8:2]] == (32'hA5A5_0000 | 32'(a[8:2])), "R4 error word only when due", mem[a[8:2]], 32'hA5A5_0000 | 32'(a[8:2]));
                    chk(!fault && new_sp == base - 32'(4 * n), "R2 final sp", new_sp, base - 32'(4 * n));
                    chk(new_ss == (xl ? t_ss(gl) : cur_ss), "R3 new ss", new_ss, xl ? t_ss(gl) : cur_ss);
                    chk(new_cs == (g_sel(8'(v)) | 16'(gl)) && new_ip == g_off(8'(v)) && new_lvl == gl,
                        "R5 handler entry", {new_cs, new_ip}, {g_sel(8'(v)) | 16'(gl), g_off(8'(v))});
                    fl = tr ? cur_flags : (cur_flags & ~32'h200);
                    chk(new_flags == fl, "R6 flag update", new_flags, fl);
                end
            end
        end

        // Overflow trap with and without the overflow flag.
        fill_mem(); set_cur(3, 32'h0A46);
        @(negedge clk); ovf_req = 1; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && new_ip == g_off(8'd4), "R7 overflow trap taken", new_ip, g_off(8'd4));
        fill_mem(); set_cur(3, 32'h0246);
        @(negedge clk); ovf_req = 1; @(negedge clk); clear_reqs();
        wait_done(20, got);
        chk(!got && ready && mem_clean(), "R7 overflow clear ignored", 64'(got), 0);

        // External interrupts gated by the enable flag; NMI is not.
        fill_mem(); set_cur(3, 32'h0A46);
        @(negedge clk); ext_req = 1; ext_vec = 8'd40; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && new_ip == g_off(8'd40), "R8 external taken", new_ip, g_off(8'd40));
        fill_mem(); set_cur(3, 32'h0846);
        @(negedge clk); ext_req = 1; @(negedge clk); clear_reqs();
        wait_done(20, got);
        chk(!got && mem_clean(), "R8 external masked", 64'(got), 0);
        @(negedge clk); nmi_req = 1; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && new_ip == g_off(8'd2), "R8 nmi ignores mask", new_ip, g_off(8'd2));

        // Same-cycle requests: priority and dropped losers.
        set_cur(3, 32'h0A46);
        @(negedge clk); nmi_req = 1; ext_req = 1; ext_vec = 8'd40; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && new_ip == g_off(8'd2), "R12 nmi beats external", new_ip, g_off(8'd2));
        wait_done(20, got);
        chk(!got, "R12 loser dropped", 64'(got), 0);
        @(negedge clk); exc_req = 1; exc_vec = 8'd13; exc_err = 32'h55; nmi_req = 1; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && new_ip == g_off(8'd13), "R12 exception beats nmi", new_ip, g_off(8'd13));
        @(negedge clk); nmi_req = 1; @(negedge clk); clear_reqs(); ext_req = 1;
        @(negedge clk); @(negedge clk); ext_req = 0;
        wait_done(40, got);
        chk(got && new_ip == g_off(8'd2), "R12 busy sequence", new_ip, g_off(8'd2));
        wait_done(20, got);
        chk(!got, "R12 busy request ignored", 64'(got), 0);

        // Return at the same level.
        fill_mem(); set_cur(1, 32'h0846);
        mem[32'h0F0 >> 2] = 32'h0000_1234; mem[32'h0F4 >> 2] = 32'h0000_0901; mem[32'h0F8 >> 2] = 32'h0000_0A02;
        @(negedge clk); iret_req = 1; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && !fault && new_ip == 32'h1234 && new_cs == 16'h0901 && new_flags == 32'h0A02,
            "R10 same-level restore", {new_ip, new_flags}, {32'h1234, 32'h0A02});
        chk(new_sp == 32'h0FC && new_ss == cur_ss && new_lvl == 2'd1, "R10 sp advanced", new_sp, 32'h0FC);

        // Return to a less privileged level.
        set_cur(0, 32'h0846);
        mem[32'h0F4 >> 2] = 32'h0000_0903; mem[32'h0FC >> 2] = 32'h0000_0180; mem[32'h100 >> 2] = 32'h0000_0063;
        @(negedge clk); iret_req = 1; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && !fault && new_sp == 32'h180 && new_ss == 16'h0063 && new_lvl == 2'd3 && new_ip == 32'h1234,
            "R11 stack restored", {new_sp, 16'h0, new_ss}, {32'h180, 32'h63});

        // Return to a more privileged level faults.
        set_cur(2, 32'h0846);
        mem[32'h0F4 >> 2] = 32'h0000_0901;
        @(negedge clk); iret_req = 1; @(negedge clk); clear_reqs();
        wait_done(40, got);
        chk(got && fault && new_ip == cur_ip && new_sp == cur_sp && new_lvl == 2'd2 && new_flags == cur_flags,
            "R13 return fault", {new_ip, new_sp}, {cur_ip, cur_sp});

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule